// File: doc/BRIEF.md
# Prioritized Reference Clock Selector

This block decides which of several reference clock inputs feeds a downstream PLL. Each input carries two alarm levels, a loss-of-signal alarm and an out-of-frequency alarm. Both arrive already synchronized to the block clock. A per-input enable bit for each alarm decides whether that alarm makes the input unusable. An input must also stay usable for a programmable number of cycles before the selector may pick it. This qualification stops the selector from chattering on a flapping alarm.

In automatic mode the selector ranks the inputs by a programmable rank value and picks the best eligible one. It then either keeps tracking the best input (revertive) or stays on its current input while that input remains healthy (non-revertive). In manual mode the wanted input comes from a 2-bit pin code or from a register field. A configuration bit decides which of the two sources is used. When nothing usable can be selected, the block raises a holdover flag. Every new selection produces a one-cycle switch pulse, which downstream phase build-out logic can use to capture the phase offset.

Top module: `refsel_top`

## Requirements
- R1: Input i is valid when not (los_i[i] and los_en_i[i]) and not (oof_i[i] and oof_en_i[i]). An alarm whose enable bit is 0 has no effect on selection.
- R2: An input becomes eligible only after it has been valid at qual_cycles_i consecutive clock edges. It loses eligibility in the same cycle it becomes invalid. With qual_cycles_i = 0, a valid input is eligible at once.
- R3: In automatic mode the candidate is the eligible input with the lowest rank value. A tie goes to the lower input index. Rank field i is rank_i[i*RANK_W +: RANK_W]. The all-ones rank value excludes that input from automatic selection.
- R4: In automatic revertive mode (revert_i=1), sel_idx_o moves to the candidate whenever the candidate differs from the current input. This includes returning to a higher-priority input after it requalifies.
- R5: In automatic non-revertive mode (revert_i=0), the selection stays on the current input for as long as that input is eligible.
- R6: In automatic mode, if the current input is not eligible and there is no candidate, holdover_o is 1. Holdover ends at the first edge where a candidate exists, and that candidate is selected.
- R7: In manual mode (auto_i=0), the target is sel_reg_i when src_reg_i=1 and sel_pins_i when src_reg_i=0. The unused source has no effect. Rank is ignored.
- R8: In manual mode, if the target is not eligible, holdover_o is 1 and sel_idx_o keeps its last value. The target is taken at the first edge where it is eligible.
- R9: switch_pulse_o is 1 for exactly the cycle in which a selection appears that differs from the previous output. This covers a different index, or any index after holdover. Entering holdover gives no pulse.
- R10: After reset, holdover_o=1, sel_valid_o=0, sel_idx_o=0 and switch_pulse_o=0.
- R11: sel_valid_o is always the inverse of holdover_o. All outputs are registered and change one edge after the eligibility or control inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| los_i | input | N_IN | Loss-of-signal alarm per input |
| oof_i | input | N_IN | Out-of-frequency alarm per input |
| los_en_i | input | N_IN | 1 = loss-of-signal alarm counts against validity |
| oof_en_i | input | N_IN | 1 = out-of-frequency alarm counts against validity |
| rank_i | input | N_IN*RANK_W | Rank per input, lower is preferred, all-ones disables |
| qual_cycles_i | input | QUAL_W | Consecutive valid edges needed for eligibility |
| auto_i | input | 1 | 1 = automatic selection, 0 = manual |
| revert_i | input | 1 | 1 = revertive automatic policy |
| src_reg_i | input | 1 | Manual source: 1 = register field, 0 = pins |
| sel_pins_i | input | IDX_W | Manual select pin code |
| sel_reg_i | input | IDX_W | Manual select register field |
| sel_idx_o | output | IDX_W | Selected input index |
| sel_valid_o | output | 1 | 1 when an input is selected |
| holdover_o | output | 1 | 1 when no usable input is selected |
| switch_pulse_o | output | 1 | One-cycle pulse on each new selection |

## Verification
Every output is a register, so a change on an alarm, a rank, a mode bit or a select code shows up at the first rising edge after it is applied. The exception is a newly valid input: qualification adds qual_cycles_i further edges, so it is selected at edge qual_cycles_i+1. The bench drives every input on the falling edge and advances a reference model by one edge in the same step. It compares all four outputs on the next falling edge, so each expected value is due exactly one edge after its stimulus. The directed qualification case also checks by hand that the selection is still absent after qual_cycles_i edges and present after one more.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  // An input is usable when no enabled alarm is raised.
  function automatic logic alarm_free(input logic los, input logic oof,
                                      input logic los_en, input logic oof_en);
    return !(los && los_en) && !(oof && oof_en);
  endfunction

  typedef enum logic [0:0] {ST_HOLD = 1'b0, ST_LOCK = 1'b1} sel_state_e;

endpackage

// File: rtl/refsel_qual.sv
module refsel_qual #(
  parameter int QUAL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_ok_i,
  input  logic [QUAL_W-1:0] qual_cycles_i,
  output logic              eligible_o
);
  logic [QUAL_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_q <= '0;
    else if (!raw_ok_i)          run_q <= '0;
    else if (run_q < qual_cycles_i) run_q <= run_q + 1'b1;
  end

  assign eligible_o = raw_ok_i && (run_q >= qual_cycles_i);

  // R2
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_ok_i |=> (run_q == '0));
endmodule

// File: rtl/refsel_pick.sv
module refsel_pick #(
  parameter int N_IN   = 4,
  parameter int RANK_W = 3,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]        elig_i,
  input  logic [N_IN*RANK_W-1:0] rank_i,
  output logic [IDX_W-1:0]       best_o,
  output logic                   found_o
);
  localparam logic [RANK_W-1:0] RANK_OFF = '1;
  logic [RANK_W-1:0] best_rank;

  always_comb begin
    found_o   = 1'b0;
    best_o    = '0;
    best_rank = RANK_OFF;
    for (int i = 0; i < N_IN; i++) begin
      if (elig_i[i] && rank_i[i*RANK_W +: RANK_W] != RANK_OFF &&
          (!found_o || rank_i[i*RANK_W +: RANK_W] < best_rank)) begin
        found_o   = 1'b1;
        best_o    = IDX_W'(i);
        best_rank = rank_i[i*RANK_W +: RANK_W];
      end
    end
  end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int N_IN = 4,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  qual_i,
  input  logic [IDX_W-1:0] best_i,
  input  logic             found_i,
  input  logic             auto_i,
  input  logic             revert_i,
  input  logic             src_reg_i,
  input  logic [IDX_W-1:0] sel_pins_i,
  input  logic [IDX_W-1:0] sel_reg_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             hold_o,
  output logic             pulse_o
);
  sel_state_e       st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             pulse_q, pulse_n;

  // Named events for the checks below.
  logic [IDX_W-1:0] man_tgt;
  logic             man_tgt_ok;
  logic             cur_ok;
  logic             need_move;

  assign man_tgt    = src_reg_i ? sel_reg_i : sel_pins_i;
  assign man_tgt_ok = (int'(man_tgt) < N_IN) && qual_i[man_tgt];
  assign cur_ok     = (st_q == ST_LOCK) && qual_i[idx_q];
  assign need_move  = auto_i && !cur_ok;

  always_comb begin
    st_n  = st_q;
    idx_n = idx_q;
    if (!auto_i) begin
      if (man_tgt_ok) begin
        st_n  = ST_LOCK;
        idx_n = man_tgt;
      end else begin
        st_n  = ST_HOLD;
      end
    end else if (need_move) begin
      if (found_i) begin
        st_n  = ST_LOCK;
        idx_n = best_i;
      end else begin
        st_n  = ST_HOLD;
      end
    end else if (revert_i && found_i && best_i != idx_q) begin
      idx_n = best_i;
    end
    pulse_n = (st_n == ST_LOCK) && ((st_q == ST_HOLD) || (idx_n != idx_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HOLD;
      idx_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      pulse_q <= pulse_n;
    end
  end

  assign idx_o   = idx_q;
  assign hold_o  = (st_q == ST_HOLD);
  assign pulse_o = pulse_q;

  // R9
  pulse_means_new_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> ((st_q == ST_LOCK) && (($past(st_q) == ST_HOLD) || (idx_q != $past(idx_q)))));

  // R5
  nonrevert_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_i && !revert_i && cur_ok) |=> $stable(idx_q) && (st_q == ST_LOCK));

  // R6
  auto_holdover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_i && !cur_ok && !found_i) |=> (st_q == ST_HOLD));

  // R8
  manual_holdover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_i && !man_tgt_ok) |=> ((st_q == ST_HOLD) && $stable(idx_q)));

  // R3
  pick_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_i |-> qual_i[best_i]);
endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int RANK_W = 3,
  parameter int QUAL_W = 8,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        los_i,
  input  logic [N_IN-1:0]        oof_i,
  input  logic [N_IN-1:0]        los_en_i,
  input  logic [N_IN-1:0]        oof_en_i,
  input  logic [N_IN*RANK_W-1:0] rank_i,
  input  logic [QUAL_W-1:0]      qual_cycles_i,
  input  logic                   auto_i,
  input  logic                   revert_i,
  input  logic                   src_reg_i,
  input  logic [IDX_W-1:0]       sel_pins_i,
  input  logic [IDX_W-1:0]       sel_reg_i,
  output logic [IDX_W-1:0]       sel_idx_o,
  output logic                   sel_valid_o,
  output logic                   holdover_o,
  output logic                   switch_pulse_o
);
  logic [N_IN-1:0]  raw_ok;
  logic [N_IN-1:0]  elig;
  logic [IDX_W-1:0] best;
  logic             found;
  logic             hold;

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    assign raw_ok[g] = alarm_free(los_i[g], oof_i[g], los_en_i[g], oof_en_i[g]);
    refsel_qual #(.QUAL_W(QUAL_W)) u_qual (
      .clk           (clk),
      .rst_n         (rst_n),
      .raw_ok_i      (raw_ok[g]),
      .qual_cycles_i (qual_cycles_i),
      .eligible_o    (elig[g])
    );
  end

  refsel_pick #(.N_IN(N_IN), .RANK_W(RANK_W)) u_pick (
    .elig_i  (elig),
    .rank_i  (rank_i),
    .best_o  (best),
    .found_o (found)
  );

  refsel_ctrl #(.N_IN(N_IN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .qual_i     (elig),
    .best_i     (best),
    .found_i    (found),
    .auto_i     (auto_i),
    .revert_i   (revert_i),
    .src_reg_i  (src_reg_i),
    .sel_pins_i (sel_pins_i),
    .sel_reg_i  (sel_reg_i),
    .idx_o      (sel_idx_o),
    .hold_o     (hold),
    .pulse_o    (switch_pulse_o)
  );

  assign holdover_o  = hold;
  assign sel_valid_o = !hold;

  // R1
  invalid_not_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((los_i & los_en_i) | (oof_i & oof_en_i)) & elig) == '0);

  // R11
  valid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o != holdover_o);
endmodule

// File: tb/tb_refsel_top.sv
module tb_refsel_top;
  localparam int N  = 4;
  localparam int RW = 3;
  localparam int QW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] los, oof, los_en, oof_en;
  logic [N*RW-1:0] rank;
  logic [QW-1:0] qual;
  logic auto_m, revert, src_reg;
  logic [IW-1:0] pins, regsel;
  logic [IW-1:0] sel_idx;
  logic sel_valid, holdover, pulse;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  int m_cnt [N];
  int m_idx;
  bit m_hold;
  bit m_pulse;

  always #5 clk = ~clk;

  refsel_top #(.N_IN(N), .RANK_W(RW), .QUAL_W(QW)) dut (
    .clk(clk), .rst_n(rst_n), .los_i(los), .oof_i(oof), .los_en_i(los_en),
    .oof_en_i(oof_en), .rank_i(rank), .qual_cycles_i(qual), .auto_i(auto_m),
    .revert_i(revert), .src_reg_i(src_reg), .sel_pins_i(pins), .sel_reg_i(regsel),
    .sel_idx_o(sel_idx), .sel_valid_o(sel_valid), .holdover_o(holdover),
    .switch_pulse_o(pulse)
  );

  function automatic bit usable(int i);
    return !((los[i] && los_en[i]) || (oof[i] && oof_en[i]));
  endfunction

  function automatic bit ready(int i);
    return usable(i) && (m_cnt[i] >= int'(qual));
  endfunction

  function automatic int rank_of(int i);
    return int'(rank[i*RW +: RW]);
  endfunction

  // Returns best eligible index, or -1 when none.
  function automatic int best_ready();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (ready(i) && rank_of(i) != 7 && (b < 0 || rank_of(i) < rank_of(b))) b = i;
    return b;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Advance model and DUT one edge, then compare on the falling edge.
  task automatic step(string req);
    int b, n_idx, tgt;
    bit n_hold;
    b = best_ready();
    n_idx = m_idx;
    n_hold = m_hold;
    tgt = src_reg ? int'(regsel) : int'(pins);
    if (!auto_m) begin
      if (ready(tgt)) begin n_idx = tgt; n_hold = 0; end
      else n_hold = 1;
    end else if (m_hold || !ready(m_idx)) begin
      if (b >= 0) begin n_idx = b; n_hold = 0; end
      else n_hold = 1;
    end else if (revert && b >= 0 && b != m_idx) begin
      n_idx = b;
    end
    m_pulse = !n_hold && (m_hold || n_idx != m_idx);
    m_idx = n_idx;
    m_hold = n_hold;
    for (int i = 0; i < N; i++)
      m_cnt[i] = usable(i) ? ((m_cnt[i] < int'(qual)) ? m_cnt[i] + 1 : m_cnt[i]) : 0;
    @(posedge clk);
    @(negedge clk);
    check(req, "holdover", int'(holdover), int'(m_hold));
    check(req, "sel_valid", int'(sel_valid), int'(!m_hold));
    check(req, "switch_pulse", int'(pulse), int'(m_pulse));
    if (!m_hold) check(req, "sel_idx", int'(sel_idx), m_idx);
  endtask

  task automatic run(int n, string req);
    for (int k = 0; k < n; k++) step(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5179));
    los = '0; oof = '0; los_en = '1; oof_en = '1;
    rank = {3'd7, 3'd3, 3'd1, 3'd2};
    qual = 8'd3; auto_m = 1; revert = 1; src_reg = 0; pins = 0; regsel = 0;
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    m_idx = 0; m_hold = 1; m_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10", "holdover", int'(holdover), 1);
    check("R10", "sel_valid", int'(sel_valid), 0);
    check("R10", "sel_idx", int'(sel_idx), 0);
    check("R10", "switch_pulse", int'(pulse), 0);

    // R2: three edges of qualification, selection at the fourth
    run(3, "R2");
    check("R2", "still holdover after qual edges", int'(holdover), 1);
    step("R3");
    check("R3", "best rank picked", int'(sel_idx), 1);
    check("R9", "pulse on first selection", int'(pulse), 1);
    step("R9");
    check("R9", "pulse lasts one cycle", int'(pulse), 0);

    // R4: fault on preferred input, then revert after requalification
    los[1] = 1; step("R6");
    check("R4", "fallback to next rank", int'(sel_idx), 0);
    los[1] = 0; run(3, "R4");
    check("R4", "no revert before qualified", int'(sel_idx), 0);
    step("R4");
    check("R4", "reverted", int'(sel_idx), 1);

    // R5: non-revertive stays put
    revert = 0; los[1] = 1; step("R5");
    los[1] = 0; run(10, "R5");
    check("R5", "stays on fallback", int'(sel_idx), 0);

    // R1: a masked alarm has no effect, an enabled one does
    oof_en[0] = 0; oof[0] = 1; run(4, "R1");
    check("R1", "masked alarm ignored", int'(sel_idx), 0);
    oof_en[0] = 1; step("R1");
    check("R1", "enabled alarm moves", int'(sel_idx), 1);
    oof[0] = 0;

    // R6 and R3: all lost, only disabled-rank input returns -> holdover
    los = '1; step("R6");
    check("R6", "holdover with no input", int'(holdover), 1);
    los[3] = 0; run(6, "R3");
    check("R3", "disabled rank not chosen", int'(holdover), 1);
    los[2] = 0; run(4, "R6");
    check("R6", "leave holdover", int'(sel_idx), 2);

    // R7 and R8: manual sources
    los = '0; run(4, "R7");
    auto_m = 0; src_reg = 1; regsel = 2'd0; pins = 2'd3; step("R7");
    check("R7", "register source", int'(sel_idx), 0);
    pins = 2'd1; step("R7");
    check("R7", "pins ignored", int'(sel_idx), 0);
    src_reg = 0; step("R7");
    check("R7", "pin source", int'(sel_idx), 1);
    los[1] = 1; step("R8");
    check("R8", "manual invalid holdover", int'(holdover), 1);
    los[1] = 0; run(4, "R8");
    check("R8", "manual target requalified", int'(sel_idx), 1);

    // Random mix
    for (int k = 0; k < 6000; k++) begin
      if ($urandom % 6 == 0) begin
        if ($urandom % 2 == 0) los[$urandom % N] ^= 1'b1;
        else oof[$urandom % N] ^= 1'b1;
      end
      if ($urandom % 80 == 0) begin los_en = N'($urandom); oof_en = N'($urandom); end
      if ($urandom % 150 == 0) rank = (N*RW)'($urandom);
      if ($urandom % 120 == 0) begin auto_m = 1'($urandom); revert = 1'($urandom); end
      if ($urandom % 60 == 0) begin src_reg = 1'($urandom); pins = IW'($urandom); regsel = IW'($urandom); end
      if ($urandom % 300 == 0) qual = QW'($urandom % 5);
      if (!auto_m) step("R7");
      else if (revert) step("R4");
      else step("R5");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule